// File: doc/BRIEF.md
# Main/Sub Clock Switching Controller

This controller chooses which of two oscillators drives the system clock: a fast main oscillator or a slow, always-running subclock. Software works through one byte-wide register. It holds a request bit for the wanted source, a read-only bit that shows the source actually in use, and a two-bit code that picks the stabilization wait. When software moves the system to the subclock, the main oscillator is switched off and the timebase timer is stopped. When it moves the system back, the oscillator is switched on again, and the clock source does not change until a stabilization count, clocked by the subclock, has run out.

All control state lives in the subclock domain, because that clock never stops. The output clock comes from a glitch-free multiplexer. Each side of the multiplexer takes its enable through a two-flop synchronizer and then changes it on the falling edge of its own clock, so the output never carries a runt pulse. After reset the block asks for the main clock. If the oscillator was not running when reset ended, the block can first run the longest stabilization wait. A parameter sets which reset sources lead to that wait.

Top module: `clksw_ctrl`

## Requirements
- R1: Register bit 0 is the source request: writing 1 asks for the main clock and writing 0 asks for the subclock. A read returns the last value written.
- R2: Register bit 1 is read-only and shows the source in use (1 = main, 0 = subclock). Writes to it have no effect. It changes only after the multiplexer handover has completed.
- R3: `osc_en` is low while the subclock is in use and the switch to it has completed. `osc_en` is high whenever bit 1 reads 1.
- R4: `tbt_en` is high only while the main clock is in use and low in subclock mode.
- R5: After a request to return to the main clock, `osc_en` rises at once. Bit 1 stays 0 until the selected wait has elapsed and `osc_ready` is high, and it rises no more than 20 subclock cycles after the wait ends.
- R6: Register bits [3:2] select the wait: code 0 = 16, 1 = 64, 2 = 256 and 3 = 1024 subclock cycles.
- R7: Writes to bits [3:2] take effect only while the main clock is in use and no switch is in progress. At any other time they are ignored.
- R8: Writing 0 to bit 0 during a stabilization wait aborts the wait. `osc_en` falls within two cycles and bit 1 stays 0.
- R9: The two multiplexer enables are never high together. `sys_clk` follows the main clock in main mode and the subclock in subclock mode.
- R10: Reset leaves bit 0 at 1 and the code at 3. If `osc_ready` is high on the first cycle after reset, bit 1 reads 1 within 14 cycles, with no wait.
- R11: If `osc_ready` is low on the first cycle after reset, the full code-3 wait is inserted when HAS_POR = 1. When HAS_POR = 0, the wait is inserted only if `rst_soft` is high; otherwise the block goes straight to the main clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_clk | input | 1 | Always-running subclock; clocks all control state |
| main_clk | input | 1 | Main oscillator clock; static while the oscillator is off |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_soft | input | 1 | High when the reset came from software or a watchdog; sampled on the first cycle after reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| osc_ready | input | 1 | Main oscillator reports stable oscillation |
| osc_en | output | 1 | Main oscillator enable |
| sys_clk | output | 1 | Glitch-free selected system clock |
| tbt_en | output | 1 | Timebase timer run enable |

## Verification
The assertions check on every subclock cycle the invariants that must always hold. The oscillator is never off while the main clock shows as in use. The timebase never runs without the oscillator. The two multiplexer enables never overlap. The wait code never changes while locked. The request bit takes each written value. A return to the main clock from real subclock operation needs `osc_ready` and at least the shortest wait. Only the bench scenarios can show the exact wait length for each code, the abort of a wait, how the reset decision depends on the variant and the reset source, and that `sys_clk` really carries the selected clock.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  // Register field positions
  localparam int SEL_BIT  = 0;
  localparam int MON_BIT  = 1;
  localparam int CODE_LSB = 2;

  typedef enum logic [2:0] {
    CS_INIT,     // first cycle after reset: decide on wait
    CS_MAIN,     // main clock in use
    CS_TO_SUB,   // handover toward subclock
    CS_SUB,      // subclock in use, oscillator off
    CS_WAIT,     // oscillator restarting, counting
    CS_TO_MAIN   // handover toward main clock
  } cs_state_e;

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CODE_W   = 2,
  parameter logic [CODE_W-1:0] RST_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mon,
  input  logic              code_unlock,
  output logic              sel,
  output logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] rdata
);
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:CODE_MSB+1], wdata[MON_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b1;
      code <= RST_CODE;
    end else if (wr) begin
      sel <= wdata[SEL_BIT];
      if (code_unlock) code <= wdata[CODE_LSB +: CODE_W];
    end
  end

  always_comb begin
    rdata                     = '0;
    rdata[SEL_BIT]            = sel;
    rdata[MON_BIT]            = mon;
    rdata[CODE_LSB +: CODE_W] = code;
  end
endmodule

// File: rtl/clksw_stab_cnt.sv
module clksw_stab_cnt #(
  parameter int BASE_LOG2 = 4,
  parameter int STEP_LOG2 = 2,
  parameter int CODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              done
);
  localparam int MAX_LOG2 = BASE_LOG2 + STEP_LOG2 * ((1 << CODE_W) - 1);
  localparam int CNT_W    = MAX_LOG2 + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;

  always_comb target = CNT_W'(1) << (BASE_LOG2 + STEP_LOG2 * int'(code));

  assign done = (cnt == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (run && !done)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
#(
  parameter bit HAS_POR = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic mon,
  input  logic sub_active,
  input  logic osc_ready,
  input  logic rst_soft,
  input  logic cnt_done,
  output logic osc_en,
  output logic req_main,
  output logic cnt_clear,
  output logic cnt_run,
  output logic code_unlock
);
  cs_state_e state, nxt;
  logic      need_wait;

  assign need_wait = !osc_ready && (HAS_POR || rst_soft);

  always_comb begin
    nxt = state;
    unique case (state)
      CS_INIT:    nxt = need_wait ? CS_WAIT : CS_TO_MAIN;
      CS_MAIN:    if (!sel) nxt = CS_TO_SUB;
      CS_TO_SUB:  if (sel) nxt = CS_TO_MAIN;
                  else if (!mon && sub_active) nxt = CS_SUB;
      CS_SUB:     if (sel) nxt = CS_WAIT;
      CS_WAIT:    if (!sel) nxt = CS_SUB;
                  else if (cnt_done && osc_ready) nxt = CS_TO_MAIN;
      CS_TO_MAIN: if (!sel) nxt = CS_TO_SUB;
                  else if (mon) nxt = CS_MAIN;
      default:    nxt = CS_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= CS_INIT;
    else        state <= nxt;

  assign osc_en      = (state != CS_SUB);
  assign req_main    = (state == CS_MAIN) || (state == CS_TO_MAIN);
  assign cnt_run     = (state == CS_WAIT);
  assign cnt_clear   = (state != CS_WAIT);
  assign code_unlock = (state == CS_MAIN) && mon;
endmodule

// File: rtl/clksw_gfmux.sv
module clksw_gfmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic main_clk,
  input  logic sub_clk,
  input  logic rst_n,
  input  logic req_main,
  output logic clk_out,
  output logic en_main,
  output logic en_sub,
  output logic main_in_use
);
  logic main_q, sub_q;

  // Main side: enable only once the subclock side has let go
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_main (
    .clk(main_clk), .rst_n(rst_n), .d(req_main & ~en_sub), .q(main_q));

  always_ff @(negedge main_clk or negedge rst_n)
    if (!rst_n) en_main <= 1'b0;
    else        en_main <= main_q;

  // Subclock side: enable only once the main side has let go
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sub (
    .clk(sub_clk), .rst_n(rst_n), .d(~req_main & ~en_main), .q(sub_q));

  always_ff @(negedge sub_clk or negedge rst_n)
    if (!rst_n) en_sub <= 1'b1;
    else        en_sub <= sub_q;

  // Report the main enable back into the control domain
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mon (
    .clk(sub_clk), .rst_n(rst_n), .d(en_main), .q(main_in_use));

  assign clk_out = (main_clk & en_main) | (sub_clk & en_sub);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter bit HAS_POR     = 1'b1,
  parameter int BASE_LOG2   = 4,
  parameter int STEP_LOG2   = 2,
  parameter int CODE_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sub_clk,
  input  logic              main_clk,
  input  logic              rst_n,
  input  logic              rst_soft,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              osc_ready,
  output logic              osc_en,
  output logic              sys_clk,
  output logic              tbt_en
);
  logic              sel, mon, unlock;
  logic [CODE_W-1:0] code;
  logic              req_main, cnt_clear, cnt_run, cnt_done;
  logic              mux_en_main, mux_en_sub;

  clksw_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk(sub_clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .mon(mon), .code_unlock(unlock), .sel(sel), .code(code), .rdata(reg_rdata));

  clksw_fsm #(.HAS_POR(HAS_POR)) u_fsm (
    .clk(sub_clk), .rst_n(rst_n), .sel(sel), .mon(mon), .sub_active(mux_en_sub),
    .osc_ready(osc_ready), .rst_soft(rst_soft), .cnt_done(cnt_done),
    .osc_en(osc_en), .req_main(req_main), .cnt_clear(cnt_clear),
    .cnt_run(cnt_run), .code_unlock(unlock));

  clksw_stab_cnt #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .CODE_W(CODE_W)) u_cnt (
    .clk(sub_clk), .rst_n(rst_n), .clear(cnt_clear), .run(cnt_run),
    .code(code), .done(cnt_done));

  clksw_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .main_clk(main_clk), .sub_clk(sub_clk), .rst_n(rst_n), .req_main(req_main),
    .clk_out(sys_clk), .en_main(mux_en_main), .en_sub(mux_en_sub),
    .main_in_use(mon));

  assign tbt_en = mon;
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk #(
  parameter int MIN_WAIT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       wsel,
  input logic       sel_rd,
  input logic       mon,
  input logic [1:0] code,
  input logic       osc_en,
  input logic       osc_ready,
  input logic       tbt_en,
  input logic       en_main,
  input logic       en_sub
);
  logic was_sub;
  int   wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_sub <= 1'b0;
      wcnt    <= 0;
    end else begin
      if (!osc_en)  was_sub <= 1'b1;
      else if (mon) was_sub <= 1'b0;
      if (!osc_en)                      wcnt <= 0;
      else if (!mon && wcnt < MIN_WAIT) wcnt <= wcnt + 1;
    end
  end

  AST_SEL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (sel_rd == $past(wsel))); // R1
  AST_NO_MAIN_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !mon); // R3
  AST_TBT_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    tbt_en |-> osc_en); // R4
  AST_RETURN_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mon) && was_sub) |-> (osc_ready && wcnt >= MIN_WAIT)); // R5
  AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mon) |=> $stable(code)); // R7
  AST_CODE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(code)); // R7
  AST_MUX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_main && en_sub)); // R9
endmodule

bind clksw_ctrl clksw_ctrl_chk #(.MIN_WAIT(1 << BASE_LOG2)) u_chk (
  .clk(sub_clk), .rst_n(rst_n), .reg_wr(reg_wr), .wsel(reg_wdata[0]),
  .sel_rd(reg_rdata[0]), .mon(reg_rdata[1]), .code(reg_rdata[3:2]),
  .osc_en(osc_en), .osc_ready(osc_ready), .tbt_en(tbt_en),
  .en_main(mux_en_main), .en_sub(mux_en_sub));

// File: tb/tb_clksw_ctrl.sv
module tb_clksw_ctrl;
  // 50 MHz subclock (20 ns period), faster gated main clock
  logic sub_clk = 0, main_clk = 0, rst_n = 0, rst_soft = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic osc_ready = 0;
  wire [7:0] reg_rdata;
  wire osc_en, sys_clk, tbt_en;

  logic mc_free = 0, rst_np = 0, rst_soft_np = 0, rdy_np = 0;
  wire [7:0] rd_np;
  wire osc_en_np, sys_np, tbt_np;

  int checks = 0, fails = 0, rdy_cnt = 0;

  always #10 sub_clk = ~sub_clk;
  always #3 main_clk = osc_en ? ~main_clk : 1'b0;
  always #3 mc_free = ~mc_free;

  // Oscillator model: ready 8 subclock cycles after enable
  always @(posedge sub_clk) begin
    if (!osc_en) begin rdy_cnt <= 0; osc_ready <= 0; end
    else if (rdy_cnt >= 7) osc_ready <= 1;
    else rdy_cnt <= rdy_cnt + 1;
  end

  clksw_ctrl dut (
    .sub_clk(sub_clk), .main_clk(main_clk), .rst_n(rst_n), .rst_soft(rst_soft),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .osc_ready(osc_ready), .osc_en(osc_en), .sys_clk(sys_clk), .tbt_en(tbt_en));

  clksw_ctrl #(.HAS_POR(1'b0)) dut_np (
    .sub_clk(sub_clk), .main_clk(mc_free), .rst_n(rst_np), .rst_soft(rst_soft_np),
    .reg_wr(1'b0), .reg_wdata(8'h00), .reg_rdata(rd_np),
    .osc_ready(rdy_np), .osc_en(osc_en_np), .sys_clk(sys_np), .tbt_en(tbt_np));

  function automatic int exp_len(input logic [1:0] c);
    return 1 << (4 + 2 * int'(c));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [1:0] c, input bit mbit);
    @(negedge sub_clk);
    reg_wr = 1; reg_wdata = {4'b0, c, mbit, s};
    @(negedge sub_clk);
    reg_wr = 0;
  endtask

  task automatic count_mon(input bit want, input int limit, output int n);
    n = 0;
    while (reg_rdata[1] != want && n < limit) begin @(negedge sub_clk); n++; end
  endtask

  task automatic sample_main_follow();
    @(negedge sub_clk);
    if (($time + 1) % 3 == 0) #2; else #1;
    check(sys_clk == main_clk, "R9 sys_clk follows main", sys_clk, main_clk);
  endtask

  initial begin
    repeat (150000) @(posedge sub_clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] code;
    // ---- R10: reset with the oscillator already ready
    repeat (20) @(negedge sub_clk);
    rst_n = 1;
    check(reg_rdata[0] == 1, "R10 select after reset", reg_rdata[0], 1);
    check(reg_rdata[3:2] == 2'd3, "R10 code after reset", reg_rdata[3:2], 3);
    count_mon(1, 200, n);
    check(n <= 14, "R10 quick main after reset", n, 14);
    check(reg_rdata == 8'h0F, "R10 register image", reg_rdata, 8'h0F);
    check(tbt_en == 1, "R4 timebase runs in main", tbt_en, 1);
    check(osc_en == 1, "R3 oscillator on in main", osc_en, 1);

    // ---- R11: no-POR variant, plain reset, oscillator not ready
    @(negedge sub_clk); rst_np = 1;
    n = 0;
    while (!rd_np[1] && n < 2000) begin @(negedge sub_clk); n++; end
    check(n <= 14, "R11 no-POR plain reset skips wait", n, 14);
    // ---- R11: no-POR variant, software reset inserts the wait
    @(negedge sub_clk); rst_np = 0; rst_soft_np = 1;
    repeat (2) @(negedge sub_clk);
    rst_np = 1;
    n = 0;
    while (!rd_np[1] && n < 3000) begin
      @(negedge sub_clk); n++;
      if (n == 30) rdy_np = 1;
    end
    check(n >= 1024 && n <= 1044, "R11 no-POR soft reset waits code 3", n, 1024);

    // ---- R2: monitor bit ignores writes; R7: code writable in main
    wr(1, 2'd3, 0);
    check(reg_rdata[1] == 1, "R2 monitor write ignored", reg_rdata[1], 1);
    wr(1, 2'd0, 1);
    check(reg_rdata[3:2] == 0, "R7 code write accepted in main", reg_rdata[3:2], 0);

    // ---- Mixed directed/random rounds
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 10; r++) begin
      code = (r < 4) ? 2'(r) : 2'($urandom % 4);
      wr(1, code, 0);
      check(reg_rdata[3:2] == code, "R7 code write in main", reg_rdata[3:2], code);
      check(reg_rdata[0] == 1, "R1 select reads back 1", reg_rdata[0], 1);
      repeat (3) sample_main_follow();

      wr(0, code, 1'($urandom % 2));
      check(reg_rdata[0] == 0, "R1 select reads back 0", reg_rdata[0], 0);
      count_mon(0, 40, n);
      check(n < 40, "R2 monitor drops after handover", n, 40);
      repeat (2) @(negedge sub_clk);
      check(osc_en == 0, "R3 oscillator off in sub", osc_en, 0);
      check(tbt_en == 0, "R4 timebase stopped in sub", tbt_en, 0);
      @(posedge sub_clk); #1;
      check(sys_clk == 1, "R9 sys_clk high with subclock", sys_clk, 1);
      @(negedge sub_clk); #1;
      check(sys_clk == 0, "R9 sys_clk low with subclock", sys_clk, 0);

      wr(0, code ^ 2'($urandom % 3 + 1), 1);
      check(reg_rdata[3:2] == code, "R7 code locked in sub", reg_rdata[3:2], code);
      check(reg_rdata[1] == 0, "R2 monitor stays 0 on write", reg_rdata[1], 0);

      if (r % 3 == 1) begin
        wr(1, code, 0);
        repeat ($urandom % (exp_len(code) / 2) + 3) @(negedge sub_clk);
        check(osc_en == 1, "R5 oscillator restarted", osc_en, 1);
        check(reg_rdata[1] == 0, "R5 monitor 0 during wait", reg_rdata[1], 0);
        wr(1, code ^ 2'd1, 0);
        check(reg_rdata[3:2] == code, "R7 code locked during wait", reg_rdata[3:2], code);
        wr(0, code, 0);
        repeat (2) @(negedge sub_clk);
        check(osc_en == 0, "R8 abort stops oscillator", osc_en, 0);
        repeat (20) @(negedge sub_clk);
        check(reg_rdata[1] == 0, "R8 monitor stays sub after abort", reg_rdata[1], 0);
      end

      wr(1, code, 0);
      count_mon(1, 3000, n);
      check(n >= exp_len(code) && n <= exp_len(code) + 20,
            $sformatf("R5 R6 wait length code %0d", code), n, exp_len(code));
      check(tbt_en == 1 && osc_en == 1, "R4 timebase resumes in main", tbt_en, 1);
    end

    // ---- R11: POR variant, reset taken in subclock mode
    wr(1, 2'd0, 0);
    wr(0, 2'd0, 0);
    count_mon(0, 40, n);
    repeat (3) @(negedge sub_clk);
    check(osc_en == 0, "R3 oscillator off before reset", osc_en, 0);
    rst_n = 0; rst_soft = 0;
    repeat (2) @(negedge sub_clk);
    rst_n = 1;
    check(reg_rdata[3:2] == 3, "R10 code back to 3", reg_rdata[3:2], 3);
    count_mon(1, 3000, n);
    check(n >= 1024 && n <= 1044, "R11 POR reset from sub waits", n, 1024);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule